// File: doc/BRIEF.md
# JTAG-to-Wishbone debug memory bridge

This block lets a debugger reach system memory through the test port. It sits behind an existing TAP controller, which supplies the current instruction code and the capture, shift and update strobes of the data-register path, all sampled on the rising edge of TCK. Three instruction codes belong to the bridge. One selects a 29-bit address register. A second reads one 64-bit word. A third swaps a word: it returns the word that was stored and writes the word that was shifted in.

Every data scan under the read or swap code makes exactly one single-beat Wishbone classic cycle in the system clock domain. The word read is shifted out least significant bit first. The address then steps to the next word, so back-to-back data scans walk through memory. Requests cross from the TCK domain into the system clock domain as a toggle through a synchronizer. Address, write data and the read word are held stable while they are used, so they cross without synchronizers. The TCK period must be longer than one bus round trip.

Top module: `jtag_wb_bridge`

## Requirements
- R1: After reset the bus is idle (wb_cyc_o, wb_stb_o and wb_we_o low) and the address register holds 0.
- R2: With instruction code 4'b0101, capture loads the address register into the scan path, 29 shifts move it out on tdo least significant bit first while tdi enters, and update makes the shifted-in value the new address.
- R3: With code 4'b0110, capture starts one read cycle (wb_we_o low) at the current address, and the next 64 shifts present the word returned on wb_dat_i on tdo, least significant bit first.
- R4: Under code 4'b0110 the bits shifted in are ignored and no write cycle is issued.
- R5: With code 4'b0111, the shifts return the word stored before the scan, and update issues one write cycle (wb_we_o high) of the 64 shifted-in bits to the same address that was read.
- R6: Each update under code 4'b0110 or 4'b0111 advances the address register by one.
- R7: Once started, a cycle keeps wb_cyc_o and wb_stb_o high together with stable address, write enable and write data until wb_ack_i is seen, and it ends in the cycle after the acknowledge.
- R8: wb_sel_o is all ones during every cycle.
- R9: Any other instruction code starts no bus cycle and leaves the address register unchanged.
- R10: Each qualifying capture or update starts exactly one bus cycle, never more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst_n | input | 1 | Active-low asynchronous reset of the TCK-side logic |
| ir_code | input | 4 | Instruction code currently held by the TAP |
| dr_capture | input | 1 | Capture-DR strobe, sampled on rising tck |
| dr_shift | input | 1 | Shift-DR strobe, sampled on rising tck |
| dr_update | input | 1 | Update-DR strobe, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out of the selected bridge register |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the bus side |
| wb_cyc_o | output | 1 | Bus cycle valid |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable, high only for the swap write |
| wb_sel_o | output | 8 | Byte selects, all ones |
| wb_adr_o | output | 29 | Word address |
| wb_dat_o | output | 64 | Write data |
| wb_dat_i | input | 64 | Read data |
| wb_ack_i | input | 1 | Cycle acknowledge |

## Verification
A request reaches the bus two to three system clocks after its TCK edge, and the read word is latched one clock after the acknowledge. That is at most about nine clocks, with a random slave wait of up to three. The bench therefore runs TCK at 24 system clocks per period and samples tdo just after each falling TCK edge, a full half period after the edge that changed it. Bus effects are checked after one idle TCK period following update, when the write has had time to complete. Addresses are checked by the next address scan, which returns the old value.

// File: rtl/jwb_pkg.sv
`timescale 1ns/1ps
package jwb_pkg;
    localparam int OPC_W = 4;
    localparam logic [OPC_W-1:0] OPC_SETADR = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_PEEK   = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_SWAP   = 4'b0111;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_ADR  = 2'd1,
        ACC_DATA = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e decode_opc(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_SETADR:         return ACC_ADR;
            OPC_PEEK, OPC_SWAP: return ACC_DATA;
            default:            return ACC_NONE;
        endcase
    endfunction
endpackage

// File: rtl/jwb_sync.sv
`timescale 1ns/1ps
module jwb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q << 1;
        pipe_d[0] = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/jwb_tck_side.sv
`timescale 1ns/1ps
module jwb_tck_side
    import jwb_pkg::*;
#(
    parameter int ADDR_W = 29,
    parameter int DATA_W = 64
) (
    input  logic              tck,
    input  logic              tck_rst_n,
    input  logic [OPC_W-1:0]  ir_code,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic              dr_update,
    input  logic              tdi,
    output logic              tdo,
    input  logic [DATA_W-1:0] rd_word,
    output logic              req_tgl,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_adr,
    output logic [DATA_W-1:0] req_wdat
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [ADDR_W-1:0] adr;
        logic [ADDR_W-1:0] acc_adr;
        logic              load_pend;
        logic              tgl;
        logic              we;
        logic [DATA_W-1:0] wdat;
    } tck_st_t;

    tck_st_t   st_d, st_q;
    acc_kind_e kind;
    logic      is_swap;
    logic [DATA_W-1:0] src_word;

    always_comb begin
        kind     = decode_opc(ir_code);
        is_swap  = (ir_code == OPC_SWAP);
        src_word = st_q.load_pend ? rd_word : st_q.sh;
        st_d     = st_q;
        if (dr_capture) begin
            if (kind == ACC_ADR) begin
                st_d.sh = '0;
                st_d.sh[ADDR_W-1:0] = st_q.adr;
            end else if (kind == ACC_DATA) begin
                st_d.load_pend = 1'b1;
                st_d.acc_adr   = st_q.adr;
                st_d.we        = 1'b0;
                st_d.tgl       = ~st_q.tgl;
            end
        end else if (dr_shift) begin
            if (kind == ACC_ADR) begin
                st_d.sh = st_q.sh >> 1;
                st_d.sh[ADDR_W-1] = tdi;
            end else if (kind == ACC_DATA) begin
                st_d.sh        = {tdi, src_word[DATA_W-1:1]};
                st_d.load_pend = 1'b0;
            end
        end else if (dr_update) begin
            if (kind == ACC_ADR) begin
                st_d.adr = st_q.sh[ADDR_W-1:0];
            end else if (kind == ACC_DATA) begin
                st_d.adr       = st_q.adr + 1'b1;
                st_d.load_pend = 1'b0;
                if (is_swap) begin
                    st_d.we   = 1'b1;
                    st_d.wdat = src_word;
                    st_d.tgl  = ~st_q.tgl;
                end
            end
        end
    end

    always_ff @(posedge tck or negedge tck_rst_n) begin
        if (!tck_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign tdo      = (kind == ACC_DATA && st_q.load_pend) ? rd_word[0] : st_q.sh[0];
    assign req_tgl  = st_q.tgl;
    assign req_we   = st_q.we;
    assign req_adr  = st_q.acc_adr;
    assign req_wdat = st_q.wdat;

    logic upd_only;
    assign upd_only = dr_update && !dr_capture && !dr_shift;

    p_read_req_r3: assert property (@(posedge tck) disable iff (!tck_rst_n)
        (dr_capture && kind == ACC_DATA) |=> (req_tgl != $past(req_tgl) && !req_we));

    p_peek_no_write_r4: assert property (@(posedge tck) disable iff (!tck_rst_n)
        (upd_only && ir_code == OPC_PEEK) |=> $stable(req_tgl));

    p_swap_write_r5: assert property (@(posedge tck) disable iff (!tck_rst_n)
        (upd_only && is_swap) |=> (req_tgl != $past(req_tgl) && req_we
                                   && req_adr == $past(req_adr)));

    p_adr_step_r6: assert property (@(posedge tck) disable iff (!tck_rst_n)
        (upd_only && kind == ACC_DATA) |=> (st_q.adr == $past(st_q.adr) + 1'b1));

    p_other_ignored_r9: assert property (@(posedge tck) disable iff (!tck_rst_n)
        ((dr_capture || dr_update) && kind == ACC_NONE) |=>
            ($stable(st_q.adr) && $stable(req_tgl)));
endmodule

// File: rtl/jwb_bus_side.sv
`timescale 1ns/1ps
module jwb_bus_side #(
    parameter int ADDR_W = 29,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl_s,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_adr,
    input  logic [DATA_W-1:0] req_wdat,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i,
    output logic [DATA_W-1:0] rd_word
);
    typedef struct packed {
        logic              seen;
        logic              cyc;
        logic              we;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] rd;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic    start;

    always_comb begin
        start = (req_tgl_s != st_q.seen);
        st_d  = st_q;
        if (st_q.cyc) begin
            if (wb_ack_i) begin
                st_d.cyc = 1'b0;
                if (!st_q.we) st_d.rd = wb_dat_i;
            end
        end else if (start) begin
            st_d.seen = req_tgl_s;
            st_d.cyc  = 1'b1;
            st_d.we   = req_we;
            st_d.adr  = req_adr;
            st_d.dat  = req_wdat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_cyc_o = st_q.cyc;
    assign wb_stb_o = st_q.cyc;
    assign wb_we_o  = st_q.cyc & st_q.we;
    assign wb_adr_o = st_q.adr;
    assign wb_dat_o = st_q.dat;
    assign rd_word  = st_q.rd;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && wb_stb_o && $stable(wb_adr_o)
                                    && $stable(wb_we_o) && $stable(wb_dat_o)));

    p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);

    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wb_cyc_o) |=> (wb_cyc_o && !start));

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !wb_cyc_o) |=> !wb_cyc_o);
endmodule

// File: rtl/jtag_wb_bridge.sv
`timescale 1ns/1ps
module jtag_wb_bridge
    import jwb_pkg::*;
#(
    parameter int ADDR_W      = 29,
    parameter int DATA_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              tck,
    input  logic              tck_rst_n,
    input  logic [3:0]        ir_code,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic              dr_update,
    input  logic              tdi,
    output logic              tdo,
    input  logic              clk,
    input  logic              rst_n,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [DATA_W/8-1:0] wb_sel_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i
);
    localparam int SEL_W = DATA_W / 8;

    logic              req_tgl, req_tgl_s, req_we;
    logic [ADDR_W-1:0] req_adr;
    logic [DATA_W-1:0] req_wdat, rd_word;

    jwb_tck_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tck (
        .tck        (tck),
        .tck_rst_n  (tck_rst_n),
        .ir_code    (ir_code),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .dr_update  (dr_update),
        .tdi        (tdi),
        .tdo        (tdo),
        .rd_word    (rd_word),
        .req_tgl    (req_tgl),
        .req_we     (req_we),
        .req_adr    (req_adr),
        .req_wdat   (req_wdat)
    );

    jwb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (req_tgl),
        .dout  (req_tgl_s)
    );

    jwb_bus_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_tgl_s (req_tgl_s),
        .req_we    (req_we),
        .req_adr   (req_adr),
        .req_wdat  (req_wdat),
        .wb_cyc_o  (wb_cyc_o),
        .wb_stb_o  (wb_stb_o),
        .wb_we_o   (wb_we_o),
        .wb_adr_o  (wb_adr_o),
        .wb_dat_o  (wb_dat_o),
        .wb_dat_i  (wb_dat_i),
        .wb_ack_i  (wb_ack_i),
        .rd_word   (rd_word)
    );

    assign wb_sel_o = {SEL_W{1'b1}};

    p_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o |-> (wb_sel_o == {SEL_W{1'b1}}));
endmodule

// File: tb/sim_jtag_wb_bridge.sv
`timescale 1ns/1ps
module sim_jtag_wb_bridge;
    localparam int  AW = 29;
    localparam int  DW = 64;
    localparam time CLK_HALF = 4ns;
    localparam time TCK_HALF = 96ns;

    logic          clk = 0, rst_n = 0, tck = 0, tck_rst_n = 0;
    logic [3:0]    ir_code = 4'h0;
    logic          dr_capture = 0, dr_shift = 0, dr_update = 0, tdi = 0;
    logic          tdo;
    logic          wb_cyc_o, wb_stb_o, wb_we_o, wb_ack_i;
    logic [7:0]    wb_sel_o;
    logic [AW-1:0] wb_adr_o;
    logic [DW-1:0] wb_dat_o, wb_dat_i;

    jtag_wb_bridge u0 (
        .tck(tck), .tck_rst_n(tck_rst_n), .ir_code(ir_code),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdi(tdi), .tdo(tdo), .clk(clk), .rst_n(rst_n),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_sel_o(wb_sel_o), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
        .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
    );

    always #(CLK_HALF) clk = ~clk;

    // behavioural slave memory
    logic [DW-1:0] mem [32];
    logic [DW-1:0] exp_mem [32];
    int            wait_cnt = 0;
    int            n_rd = 0, n_wr = 0, sel_bad = 0, hold_bad = 0;
    logic [AW-1:0] last_rd_adr = '0, last_wr_adr = '0;
    logic [DW-1:0] last_wr_dat = '0;
    logic          prev_pend = 0;

    initial begin
        wb_ack_i = 0;
        wb_dat_i = '0;
    end

    always @(posedge clk) begin
        if (prev_pend && !wb_cyc_o) hold_bad++;
        if (wb_cyc_o !== wb_stb_o) hold_bad++;
        prev_pend = wb_cyc_o && !wb_ack_i;
        wb_ack_i <= 1'b0;
        if (wb_cyc_o && !wb_ack_i) begin
            if (wb_sel_o !== 8'hFF) sel_bad++;
            if (wait_cnt == 0) begin
                wb_ack_i <= 1'b1;
                wb_dat_i <= mem[wb_adr_o[4:0]];
                if (wb_we_o) begin
                    mem[wb_adr_o[4:0]] <= wb_dat_o;
                    n_wr++;
                    last_wr_adr = wb_adr_o;
                    last_wr_dat = wb_dat_o;
                end else begin
                    n_rd++;
                    last_rd_adr = wb_adr_o;
                end
                wait_cnt = int'($urandom % 4);
            end else begin
                wait_cnt--;
            end
        end
    end

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic tck_edge();
        #(TCK_HALF) tck = 1;
        #(TCK_HALF) tck = 0;
    endtask

    task automatic scan(input logic [3:0] op, input int len,
                        input logic [DW-1:0] din, output logic [DW-1:0] dout);
        ir_code = op;
        dr_capture = 1;
        tck_edge();
        dr_capture = 0;
        dout = '0;
        for (int i = 0; i < len; i++) begin
            dr_shift = 1;
            tdi = din[i];
            #1;
            dout[i] = tdo;
            tck_edge();
        end
        dr_shift = 0;
        dr_update = 1;
        tck_edge();
        dr_update = 0;
        tck_edge();
        #1;
    endtask

    logic [AW-1:0] exp_adr = '0;

    function automatic logic [DW-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic do_setadr(input logic [AW-1:0] nadr, input string tag);
        logic [DW-1:0] o;
        scan(4'b0101, AW, DW'(nadr), o);
        chk(tag, o & DW'({AW{1'b1}}), DW'(exp_adr));
        exp_adr = nadr;
    endtask

    task automatic do_peek(input string tag);
        logic [DW-1:0] o;
        int wr0, rd0;
        wr0 = n_wr; rd0 = n_rd;
        scan(4'b0110, DW, rnd64(), o);
        chk({tag, " R3 data"}, o, exp_mem[exp_adr[4:0]]);
        chk("R3 read address", DW'(last_rd_adr), DW'(exp_adr));
        chk("R4 no write", DW'(n_wr), DW'(wr0));
        chk("R10 one read", DW'(n_rd), DW'(rd0 + 1));
        exp_adr = exp_adr + 1'b1;
    endtask

    task automatic do_swap(input string tag);
        logic [DW-1:0] o, d;
        int wr0, rd0;
        wr0 = n_wr; rd0 = n_rd;
        d = rnd64();
        scan(4'b0111, DW, d, o);
        chk({tag, " R5 old word"}, o, exp_mem[exp_adr[4:0]]);
        chk("R5 write address", DW'(last_wr_adr), DW'(exp_adr));
        chk("R5 write data", last_wr_dat, d);
        chk("R10 one read one write", DW'({n_rd - rd0, n_wr - wr0}), DW'({32'd1, 32'd1}));
        exp_mem[exp_adr[4:0]] = d;
        exp_adr = exp_adr + 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] o;
        int wr0, rd0;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 32; i++) begin
            mem[i] = rnd64();
            exp_mem[i] = mem[i];
        end
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 bus idle in reset", DW'({wb_cyc_o, wb_stb_o, wb_we_o}), '0);
        rst_n = 1;
        tck_rst_n = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 bus idle after reset", DW'({wb_cyc_o, wb_stb_o, wb_we_o}), '0);

        // R1/R2: first address scan returns reset value 0
        do_setadr(29'd5, "R1 R2 reset address");
        do_setadr(29'd3, "R2 previous address");

        // R5 swap then R3 read of the next word, R6 step
        do_swap("directed");
        do_peek("directed");
        do_setadr(29'd3, "R6 address after two data scans");
        do_peek("R5 readback of written word");

        // R9: unrelated code has no effect
        wr0 = n_wr; rd0 = n_rd;
        scan(4'b1010, AW, rnd64(), o);
        chk("R9 no bus cycle", DW'({n_rd, n_wr}), DW'({rd0, wr0}));
        do_setadr(29'd30, "R9 address unchanged");

        // R6: step across the top of the modelled window
        do_swap("wrap");
        do_swap("wrap");
        do_peek("wrap");

        // random mix
        for (int k = 0; k < 18; k++) begin
            case ($urandom % 3)
                0:       do_setadr(AW'($urandom % 32), "R2 random");
                1:       do_peek("random");
                default: do_swap("random");
            endcase
        end
        do_setadr(29'd0, "R6 final address");

        chk("R8 select all ones", DW'(sel_bad), '0);
        chk("R7 hold until ack", DW'(hold_bad), '0);
        done = 1;
        summary();
        $finish;
    end
endmodule